// File: doc/BRIEF.md
# DMA Descriptor Chain Controller

This block is the chaining logic of one DMA channel. It keeps a 36-bit physical pointer to the next command descriptor, along with two status flags. The chain flag says that another descriptor should be fetched. The active flag says that the channel has work in progress. Software writes the pointer through a single host write port, and that write also updates the flags. A zero pointer field stops chaining. Any other value arms chaining and marks the channel busy.

When the data engine signals that its current transfer is finished and chaining is armed, the block reads a four-word descriptor from memory. It uses a request/response port that has one read outstanding at a time. The first three words (source, destination, byte count) go to the channel through a one-cycle load strobe. The fourth word is the link to the next descriptor. A nonzero link replaces the pointer. A zero link ends the chain and leaves the pointer on the descriptor that held it. A host write that arrives while a fetch is in flight is parked and applied once the fetch has finished.

Top module: `dma_chain_ctrl`

## Requirements
- R1: The pointer covers address bits 35:3. Host reads return the pointer in bits 35:3 with bits 63:36 and 2:0 always zero, and written values in those bits are ignored.
- R2: A host write whose bits 35:3 are nonzero, made while no fetch is running or starting, stores those bits and sets both chain_en and xfer_active on the next cycle.
- R3: A host write whose bits 35:3 are all zero clears chain_en only. xfer_active and the stored pointer keep their values.
- R4: After reset the pointer reads zero, both flags are clear, no memory request is raised, desc_load is low and desc_data is zero.
- R5: xfer_done, while no fetch is running and chain_en is set, starts a fetch. The fetch issues exactly four reads, in the order pointer, pointer+8, pointer+16, pointer+24. Each read is issued only after the previous response. mem_req_addr and mem_req_valid hold steady until mem_req_ready, and every request address has bits 2:0 zero.
- R6: In the cycle after the fourth good response, desc_load pulses for one cycle. desc_data then holds word 0 (source) in bits 63:0, word 1 (destination) in bits 127:64 and word 2 (byte count) in bits 191:128.
- R7: If bits 35:3 of the fourth word are nonzero, they replace the pointer and chain_en stays set. If they are zero, the pointer is kept and chain_en is cleared. In both cases xfer_active stays set.
- R8: xfer_done while chain_en is clear starts no fetch and clears xfer_active. xfer_done during a running fetch has no effect.
- R9: A response with mem_rsp_err set aborts the fetch. No desc_load follows, both flags are cleared, and the pointer is unchanged.
- R10: A host write made during a fetch, or in the cycle a fetch starts, is held and applied in the first cycle after the fetch ends. A later write in the same fetch replaces an earlier held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr_en | input | 1 | Host write strobe for the pointer |
| host_wr_data | input | 64 | Host write value, pointer in bits 35:3 |
| host_rd_data | output | 64 | Pointer readback |
| xfer_done | input | 1 | Current transfer finished (one-cycle pulse) |
| chain_en | output | 1 | Chaining armed |
| xfer_active | output | 1 | Channel has work in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 36 | Read byte address, 8-byte aligned |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response word |
| mem_rsp_err | input | 1 | Read response error |
| desc_load | output | 1 | One-cycle strobe: desc_data holds a new descriptor |
| desc_data | output | 192 | Descriptor payload: source, destination, byte count |

## Verification
The bench builds the block with its default parameters: 64-bit data, 36-bit addresses, 8-byte alignment and four-word descriptors. With these values the pointer-field masking, the zero-link and nonzero-link cases, and address stepping across a whole descriptor can all be exercised directly. The memory stub can stall on the request side and add response latency. Together with host writes and extra xfer_done pulses landing mid-fetch, this reaches the deferred-write, last-write-wins and error-abort paths.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [1:0] {
    FETCH_IDLE = 2'd0,
    FETCH_REQ  = 2'd1,
    FETCH_WAIT = 2'd2
  } fetch_state_e;

endpackage

// File: rtl/dma_chain_fetch.sv
module dma_chain_fetch
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W     = 36,
  parameter int ALIGN_BITS = 3,
  parameter int DESC_WORDS = 4,
  localparam int PTR_W     = ADDR_W - ALIGN_BITS,
  localparam int IDX_W     = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PTR_W-1:0]  base_ptr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              busy,
  output logic              word_ok,
  output logic [IDX_W-1:0]  word_idx,
  output logic              fetch_done,
  output logic              fetch_abort
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  fetch_state_e     state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rsp_take;

  // next-state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      FETCH_IDLE: begin
        if (start) begin
          state_d = FETCH_REQ;
          idx_d   = '0;
        end
      end
      FETCH_REQ: begin
        if (mem_req_ready) state_d = FETCH_WAIT;
      end
      FETCH_WAIT: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err || (idx_q == LAST_IDX)) begin
            state_d = FETCH_IDLE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = FETCH_REQ;
          end
        end
      end
      default: state_d = FETCH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FETCH_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign rsp_take      = (state_q == FETCH_WAIT) && mem_rsp_valid;
  assign word_ok       = rsp_take && !mem_rsp_err;
  assign fetch_done    = word_ok && (idx_q == LAST_IDX);
  assign fetch_abort   = rsp_take && mem_rsp_err;
  assign word_idx      = idx_q;
  assign busy          = (state_q != FETCH_IDLE);
  assign mem_req_valid = (state_q == FETCH_REQ);
  assign mem_req_addr  = {base_ptr, {ALIGN_BITS{1'b0}}}
                         + (ADDR_W'(idx_q) << ALIGN_BITS);

endmodule

// File: rtl/dma_chain_ptr.sv
module dma_chain_ptr #(
  parameter int ADDR_W     = 36,
  parameter int ALIGN_BITS = 3,
  localparam int PTR_W     = ADDR_W - ALIGN_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr_en,
  input  logic [PTR_W-1:0] wr_field,
  input  logic             xfer_done,
  input  logic             fetch_busy,
  input  logic             fetch_done,
  input  logic             fetch_abort,
  input  logic [PTR_W-1:0] link_ptr,
  output logic [PTR_W-1:0] ptr,
  output logic             chain_en,
  output logic             xfer_active,
  output logic             start_fetch
);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_ld;
  logic             ce_q, ce_d;
  logic             act_q, act_d;
  logic             pend_q, pend_d;
  logic [PTR_W-1:0] pdat_q, pdat_d;
  logic             pdat_ld;
  logic             hold;

  assign start_fetch = !fetch_busy && xfer_done && ce_q;
  assign hold        = fetch_busy || start_fetch;

  // next-state
  always_comb begin
    ptr_d   = ptr_q;
    ptr_ld  = 1'b0;
    ce_d    = ce_q;
    act_d   = act_q;
    pend_d  = pend_q;
    pdat_d  = pdat_q;
    pdat_ld = 1'b0;

    if (fetch_done) begin
      if (link_ptr != '0) begin
        ptr_d  = link_ptr;
        ptr_ld = 1'b1;
      end else begin
        ce_d = 1'b0;
      end
    end
    if (fetch_abort) begin
      ce_d  = 1'b0;
      act_d = 1'b0;
    end

    if (hold) begin
      if (host_wr_en) begin
        pend_d  = 1'b1;
        pdat_d  = wr_field;
        pdat_ld = 1'b1;
      end
    end else begin
      // not starting, so chain_en is clear here: end of work
      if (xfer_done) act_d = 1'b0;
      if (pend_q) begin
        pend_d = 1'b0;
        if (pdat_q != '0) begin
          ptr_d  = pdat_q;
          ptr_ld = 1'b1;
          ce_d   = 1'b1;
          act_d  = 1'b1;
        end else begin
          ce_d = 1'b0;
        end
      end
      if (host_wr_en) begin
        if (wr_field != '0) begin
          ptr_d  = wr_field;
          ptr_ld = 1'b1;
          ce_d   = 1'b1;
          act_d  = 1'b1;
        end else begin
          ce_d = 1'b0;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      ce_q   <= 1'b0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      pdat_q <= '0;
    end else begin
      if (ptr_ld)  ptr_q  <= ptr_d;
      if (pdat_ld) pdat_q <= pdat_d;
      ce_q   <= ce_d;
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  assign ptr         = ptr_q;
  assign chain_en    = ce_q;
  assign xfer_active = act_q;

endmodule

// File: rtl/dma_chain_desc.sv
module dma_chain_desc #(
  parameter int DATA_W     = 64,
  parameter int DESC_WORDS = 4,
  localparam int PAY_WORDS = DESC_WORDS - 1,
  localparam int IDX_W     = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        word_ok,
  input  logic [IDX_W-1:0]            word_idx,
  input  logic [DATA_W-1:0]           rsp_data,
  input  logic                        fetch_done,
  output logic                        desc_load,
  output logic [PAY_WORDS*DATA_W-1:0] desc_data
);

  logic load_q;

  for (genvar g = 0; g < PAY_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] out_q;
    logic              stage_en;

    assign stage_en = word_ok && (word_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        out_q   <= '0;
      end else begin
        if (stage_en)   stage_q <= rsp_data;
        if (fetch_done) out_q   <= stage_q;
      end
    end

    assign desc_data[g*DATA_W +: DATA_W] = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= fetch_done;
  end

  assign desc_load = load_q;

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl #(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 36,
  parameter int ALIGN_BITS = 3,
  parameter int DESC_WORDS = 4,
  localparam int PTR_W     = ADDR_W - ALIGN_BITS,
  localparam int PAY_WORDS = DESC_WORDS - 1,
  localparam int IDX_W     = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_wr_en,
  input  logic [DATA_W-1:0]           host_wr_data,
  output logic [DATA_W-1:0]           host_rd_data,
  input  logic                        xfer_done,
  output logic                        chain_en,
  output logic                        xfer_active,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [ADDR_W-1:0]           mem_req_addr,
  input  logic                        mem_rsp_valid,
  input  logic [DATA_W-1:0]           mem_rsp_data,
  input  logic                        mem_rsp_err,
  output logic                        desc_load,
  output logic [PAY_WORDS*DATA_W-1:0] desc_data
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [PTR_W-1:0] ptr;
  logic             start_fetch;
  logic             fetch_busy;
  logic             word_ok;
  logic [IDX_W-1:0] word_idx;
  logic             fetch_done;
  logic             fetch_abort;
  logic             unused_wr_bits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign unused_wr_bits = ^{host_wr_data[DATA_W-1:ADDR_W],
                            host_wr_data[ALIGN_BITS-1:0]};

  dma_chain_ptr #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_ptr (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .host_wr_en  (host_wr_en),
    .wr_field    (host_wr_data[ADDR_W-1:ALIGN_BITS]),
    .xfer_done   (xfer_done),
    .fetch_busy  (fetch_busy),
    .fetch_done  (fetch_done),
    .fetch_abort (fetch_abort),
    .link_ptr    (mem_rsp_data[ADDR_W-1:ALIGN_BITS]),
    .ptr         (ptr),
    .chain_en    (chain_en),
    .xfer_active (xfer_active),
    .start_fetch (start_fetch)
  );

  dma_chain_fetch #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (ALIGN_BITS),
    .DESC_WORDS (DESC_WORDS)
  ) u_fetch (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start         (start_fetch),
    .base_ptr      (ptr),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .busy          (fetch_busy),
    .word_ok       (word_ok),
    .word_idx      (word_idx),
    .fetch_done    (fetch_done),
    .fetch_abort   (fetch_abort)
  );

  dma_chain_desc #(
    .DATA_W     (DATA_W),
    .DESC_WORDS (DESC_WORDS)
  ) u_desc (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .word_ok    (word_ok),
    .word_idx   (word_idx),
    .rsp_data   (mem_rsp_data),
    .fetch_done (fetch_done),
    .desc_load  (desc_load),
    .desc_data  (desc_data)
  );

  assign host_rd_data = {{(DATA_W-ADDR_W){1'b0}}, ptr, {ALIGN_BITS{1'b0}}};

endmodule

// File: rtl/dma_chain_ctrl_chk.sv
module dma_chain_ctrl_chk #(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 36,
  parameter int ALIGN_BITS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic [DATA_W-1:0] host_wr_data,
  input logic [DATA_W-1:0] host_rd_data,
  input logic              xfer_done,
  input logic              chain_en,
  input logic              xfer_active,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_err,
  input logic              desc_load,
  input logic              fetch_busy
);

  logic live_wr;
  assign live_wr = host_wr_en && !fetch_busy && !(xfer_done && chain_en);

  // R1: readback never carries bits outside the pointer field
  a_r1_rd_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_data[DATA_W-1:ADDR_W] == '0) && (host_rd_data[ALIGN_BITS-1:0] == '0));

  // R2: nonzero write arms both flags and stores the field
  a_r2_nonzero_write: assert property (@(posedge clk) disable iff (!rst_n)
    live_wr && (host_wr_data[ADDR_W-1:ALIGN_BITS] != '0)
    |=> chain_en && xfer_active
        && (host_rd_data[ADDR_W-1:ALIGN_BITS] == $past(host_wr_data[ADDR_W-1:ALIGN_BITS])));

  // R3: zero write disarms chaining
  a_r3_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    live_wr && (host_wr_data[ADDR_W-1:ALIGN_BITS] == '0) |=> !chain_en);

  // R5: request held until accepted
  a_r5_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R5: one outstanding read
  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R5: aligned addresses
  a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[ALIGN_BITS-1:0] == '0));

  // R6: load is a single-cycle strobe and comes with active work
  a_r6_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    desc_load |=> !desc_load);
  a_r6_load_active: assert property (@(posedge clk) disable iff (!rst_n)
    desc_load |-> xfer_active);

  // R9: error response clears both flags
  a_r9_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_busy && !mem_req_valid && mem_rsp_valid && mem_rsp_err
    |=> !chain_en && !xfer_active && !desc_load);

endmodule

bind dma_chain_ctrl dma_chain_ctrl_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .ALIGN_BITS (ALIGN_BITS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .host_wr_en    (host_wr_en),
  .host_wr_data  (host_wr_data),
  .host_rd_data  (host_rd_data),
  .xfer_done     (xfer_done),
  .chain_en      (chain_en),
  .xfer_active   (xfer_active),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_err   (mem_rsp_err),
  .desc_load     (desc_load),
  .fetch_busy    (fetch_busy)
);

// File: tb/dma_chain_ctrl_bench.sv
module dma_chain_ctrl_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_wr_en = 1'b0;
  logic [63:0]  host_wr_data = '0;
  logic [63:0]  host_rd_data;
  logic         xfer_done = 1'b0;
  logic         chain_en;
  logic         xfer_active;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [35:0]  mem_req_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [63:0]  mem_rsp_data = '0;
  logic         mem_rsp_err = 1'b0;
  logic         desc_load;
  logic [191:0] desc_data;

  always #10 clk = ~clk;

  dma_chain_ctrl u_dma_chain_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .host_rd_data(host_rd_data),
    .xfer_done(xfer_done), .chain_en(chain_en), .xfer_active(xfer_active),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .desc_load(desc_load), .desc_data(desc_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ---------------- memory stub ----------------
  logic [63:0] mem [logic [35:0]];
  logic [35:0] err_addr = '0;
  bit          err_on = 1'b0;
  int          lat = 0;
  int          stall_mode = 0;
  int          rsp_cnt = -1;
  logic [35:0] rsp_addr = '0;
  int          cyc = 0;
  logic [35:0] addr_q [$];
  int          load_cnt = 0;

  function automatic logic [63:0] rd_mem(input logic [35:0] a);
    if (mem.exists(a)) return mem[a];
    return {28'h5A5, a};
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rsp_cnt == 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = rd_mem(rsp_addr);
      mem_rsp_err   = err_on && (rsp_addr == err_addr);
      rsp_cnt       = -1;
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (rsp_cnt > 0) rsp_cnt--;
    end
    mem_req_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (mem_req_valid && mem_req_ready) begin
      addr_q.push_back(mem_req_addr);
      rsp_addr = mem_req_addr;
      rsp_cnt  = lat;
    end
    if (desc_load) load_cnt++;
  end

  // ---------------- behavioural reference model ----------------
  logic [32:0] m_ptr, m_pd;
  logic        m_ce, m_act, m_pv, m_load;
  int          m_st, m_idx;
  logic [63:0] m_w [3];
  logic [63:0] m_d [3];

  task automatic m_apply(input logic [32:0] f);
    if (f != '0) begin m_ptr = f; m_ce = 1'b1; m_act = 1'b1; end
    else m_ce = 1'b0;
  endtask

  always @(posedge clk) begin : model
    logic busy, start, hold;
    if (!rst_n) begin
      m_ptr = '0; m_pd = '0; m_ce = 1'b0; m_act = 1'b0; m_pv = 1'b0;
      m_load = 1'b0; m_st = 0; m_idx = 0;
      for (int k = 0; k < 3; k++) begin m_w[k] = '0; m_d[k] = '0; end
    end else begin
      busy  = (m_st != 0);
      start = !busy && xfer_done && m_ce;
      hold  = busy || start;
      m_load = 1'b0;
      case (m_st)
        0: if (xfer_done) begin
             if (m_ce) begin m_st = 1; m_idx = 0; end
             else m_act = 1'b0;
           end
        1: if (mem_req_ready) m_st = 2;
        default: if (mem_rsp_valid) begin
             if (mem_rsp_err) begin m_ce = 1'b0; m_act = 1'b0; m_st = 0; end
             else if (m_idx == 3) begin
               if (mem_rsp_data[35:3] != '0) m_ptr = mem_rsp_data[35:3];
               else m_ce = 1'b0;
               for (int k = 0; k < 3; k++) m_d[k] = m_w[k];
               m_load = 1'b1;
               m_st = 0;
             end else begin
               m_w[m_idx] = mem_rsp_data;
               m_idx++;
               m_st = 1;
             end
           end
      endcase
      if (hold) begin
        if (host_wr_en) begin m_pv = 1'b1; m_pd = host_wr_data[35:3]; end
      end else begin
        if (m_pv) begin m_apply(m_pd); m_pv = 1'b0; end
        if (host_wr_en) m_apply(host_wr_data[35:3]);
      end
    end
  end

  bit compare_on = 1'b0;
  always @(negedge clk) begin
    if (compare_on) begin
      chk("R7", "chain_en", 256'(chain_en), 256'(m_ce));
      chk("R8", "xfer_active", 256'(xfer_active), 256'(m_act));
      chk("R1", "host_rd_data", 256'(host_rd_data), 256'({28'h0, m_ptr, 3'b000}));
      chk("R5", "mem_req_valid", 256'(mem_req_valid), 256'(m_st == 1));
      if (m_st == 1)
        chk("R5", "mem_req_addr", 256'(mem_req_addr),
            256'({m_ptr, 3'b000} + 36'(m_idx * 8)));
      chk("R6", "desc_load", 256'(desc_load), 256'(m_load));
      chk("R6", "desc_data", 256'(desc_data), 256'({m_d[2], m_d[1], m_d[0]}));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [63:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0; host_wr_data = '0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic check_addrs(input string req, input logic [35:0] base);
    chk(req, "request count", 256'(addr_q.size()), 256'(4));
    for (int k = 0; k < 4 && k < addr_q.size(); k++)
      chk(req, "request address", 256'(addr_q[k]), 256'(base + 36'(k * 8)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // descriptors
    mem[36'h1000] = 64'h1111; mem[36'h1008] = 64'h2222;
    mem[36'h1010] = 64'h40;   mem[36'h1018] = 64'hABC0_0000_0000_2005;
    mem[36'h2000] = 64'h3333; mem[36'h2008] = 64'h4444;
    mem[36'h2010] = 64'h80;   mem[36'h2018] = 64'hF000_0000_0000_0007;
    mem[36'h4018] = 64'h5000;
    mem[36'h5018] = 64'h0;

    tick(5);
    rst_n = 1'b1;
    tick(4);
    compare_on = 1'b1;
    // R4 reset state
    chk("R4", "chain_en", 256'(chain_en), 256'(0));
    chk("R4", "xfer_active", 256'(xfer_active), 256'(0));
    chk("R4", "host_rd_data", 256'(host_rd_data), 256'(0));
    chk("R4", "mem_req_valid", 256'(mem_req_valid), 256'(0));
    chk("R4", "desc_data", 256'(desc_data), 256'(0));

    // R1/R2: out-of-field bits are dropped
    host_write(64'hFFFF_F000_0000_1007);
    chk("R1", "readback masked", 256'(host_rd_data), 256'(64'h1000));
    chk("R2", "chain_en set", 256'(chain_en), 256'(1));
    chk("R2", "xfer_active set", 256'(xfer_active), 256'(1));

    // R3: zero field clears chain only
    host_write(64'hFFFF_FFF0_0000_0007);
    chk("R3", "chain_en cleared", 256'(chain_en), 256'(0));
    chk("R3", "xfer_active kept", 256'(xfer_active), 256'(1));
    chk("R3", "pointer kept", 256'(host_rd_data), 256'(64'h1000));

    // R8: completion without chaining
    addr_q.delete();
    pulse_done();
    tick(3);
    chk("R8", "xfer_active cleared", 256'(xfer_active), 256'(0));
    chk("R8", "no fetch", 256'(addr_q.size()), 256'(0));

    // R5/R6/R7: two-descriptor chain, nonzero link then zero link
    host_write(64'h1000);
    addr_q.delete();
    pulse_done();
    tick(30);
    check_addrs("R5", 36'h1000);
    chk("R6", "one load", 256'(load_cnt), 256'(1));
    chk("R6", "payload", 256'(desc_data), {64'h0, 64'h40, 64'h2222, 64'h1111});
    chk("R7", "link followed", 256'(host_rd_data), 256'(64'h2000));
    chk("R7", "chain kept", 256'(chain_en), 256'(1));

    stall_mode = 1; lat = 2;
    addr_q.delete();
    pulse_done();
    tick(40);
    check_addrs("R5", 36'h2000);
    chk("R7", "zero link keeps pointer", 256'(host_rd_data), 256'(64'h2000));
    chk("R7", "zero link ends chain", 256'(chain_en), 256'(0));
    chk("R7", "active stays", 256'(xfer_active), 256'(1));
    chk("R6", "payload 2", 256'(desc_data), {64'h0, 64'h80, 64'h4444, 64'h3333});
    pulse_done();
    tick(2);
    chk("R8", "last transfer ends", 256'(xfer_active), 256'(0));

    // R9: error on the second word
    err_on = 1'b1; err_addr = 36'h3008;
    host_write(64'h3000);
    pulse_done();
    tick(40);
    chk("R9", "chain cleared", 256'(chain_en), 256'(0));
    chk("R9", "active cleared", 256'(xfer_active), 256'(0));
    chk("R9", "pointer unchanged", 256'(host_rd_data), 256'(64'h3000));
    chk("R9", "no load", 256'(load_cnt), 256'(2));
    err_on = 1'b0;

    // R10: writes during fetch are deferred, last one wins
    lat = 3;
    host_write(64'h4000);
    addr_q.delete();
    pulse_done();
    tick(1);
    host_write(64'h7000);
    pulse_done();            // R8: ignored mid-fetch
    host_write(64'h0);
    chk("R10", "pointer held during fetch", 256'(host_rd_data), 256'(64'h4000));
    tick(40);
    check_addrs("R8", 36'h4000);
    chk("R10", "link then zero write", 256'(host_rd_data), 256'(64'h5000));
    chk("R10", "zero write applied", 256'(chain_en), 256'(0));

    host_write(64'h5000);
    pulse_done();
    tick(1);
    host_write(64'h6000);
    tick(40);
    chk("R10", "held write after zero link", 256'(host_rd_data), 256'(64'h6000));
    chk("R10", "chain rearmed", 256'(chain_en), 256'(1));
    chk("R10", "active", 256'(xfer_active), 256'(1));

    tick(5);
    report();
  end

endmodule